// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block watches a two-wire I2C bus from the slave side and decides whether the device is being addressed. It brings both bus lines into the system clock domain and finds START and STOP conditions and SCL edges. It shifts in the first byte or bytes after a START and compares the received address with a programmable own address. A per-bit don't-care mask applies to that comparison. When the address matches, the block pulls SDA low in the ninth clock to acknowledge. It then loads the byte into a buffer and raises a sticky interrupt flag. It can also pull SCL low after the eighth falling edge, so that software chooses the acknowledge value before the bus moves on.

Both 7-bit and 10-bit addressing are handled. The block also recognises the general call address (0x00 as a write) when that is enabled. After an acknowledged write address, the following bytes are taken in as data. Software reaches the block through a small register port: one write strobe, one read strobe, an address and 8-bit data. The block has only the drive requests `sda_low` and `scl_hold`. The pad logic turns them into open-drain pull-downs.

Register map, at a 3-bit address:
- 0, CFG: bit0 selects 10-bit mode, bit1 enables general call, bit2 enables address hold, and bit3 holds the ACK value (0 acknowledges, 1 refuses). Writing 1 to bit4 releases a held SCL and reads back as 0.
- 1, OWN: the own address low byte. In 7-bit mode bits 7:1 hold the address.
- 2, OWNHI: bits 1:0 hold address bits 9:8 for 10-bit mode.
- 3, MASK: the compare mask.
- 4, BUF: the receive buffer.
- 5, FLAGS: bit0 interrupt, bit1 buffer full, bit2 address-update, bit3 SCL held (read-only). Writing 1 to bit0 or bit2 clears that flag.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset CFG reads 0, MASK reads 0xFF, FLAGS reads 0, and `sda_low`, `scl_hold` and `irq` are low.
- R2: In 7-bit mode a first byte whose bits 7:1 equal OWN bits 7:1 is acknowledged: SDA is held low for the whole ninth clock. A byte that does not match is not acknowledged, and no later byte is acknowledged until the next START.
- R3: A 0 in a MASK bit makes the matching address bit a don't-care in the compare. This covers bits 7:1 in 7-bit mode and bits 7:0 of the second byte in 10-bit mode.
- R4: With general call enabled (CFG bit1), a first byte of 0x00 is acknowledged whatever OWN and MASK hold. With it disabled, 0x00 is compared like any other address.
- R5: After an acknowledged write address or general call, every following byte is acknowledged and loaded into BUF.
- R6: FLAGS bit0 and the `irq` output are set at the end of the ninth clock of every acknowledged byte, and are not set by a refused byte. The flag stays set until software writes 1 to FLAGS bit0. A write with bit0 at 0 leaves it set.
- R7: FLAGS bit1 is set when a byte is loaded into BUF and cleared by a read of BUF.
- R8: In 10-bit mode the first byte must be 11110 followed by OWNHI bits 1:0 and the R/W bit. MASK never applies to this byte. A matching first byte is acknowledged and sets FLAGS bit2. A matching second byte is acknowledged and also sets FLAGS bit2.
- R9: In 10-bit mode a general call is acknowledged without setting FLAGS bit2, and the next byte is handled as data.
- R10: With address hold enabled, the byte that completes a match makes the block do four things after its eighth falling edge: hold SCL low, leave SDA released, load BUF and set the interrupt flag. A CFG write with bit4 set releases SCL. In the ninth clock SDA is then driven low if the written bit3 is 0, and left released if it is 1. After a refusal, later bytes are ignored.
- R11: A START, including one in the middle of a byte, begins a new address byte. A STOP releases SDA and SCL and returns the block to idle.
- R12: A matching 7-bit address with R/W set is acknowledged, and the bytes that follow it are not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL level from the pad, asynchronous |
| sda_in | input | 1 | SDA level from the pad, asynchronous |
| scl_hold | output | 1 | Request to pull SCL low |
| sda_low | output | 1 | Request to pull SDA low |
| irq | output | 1 | Sticky interrupt flag |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |

## Verification
The bench drives random own addresses, masks and first bytes. Many of these bytes are chosen to differ from the own address only in masked-off bits or in bit 0. A compare that let bit 0 or a masked bit count would then acknowledge wrongly or miss an acknowledge. Directed cases go after the 10-bit first byte with an all-zero mask, and after the 10-bit general call. A design that masked the first byte would acknowledge a wrong high pair. One that set the update flag on a general call would show it in FLAGS. The hold case checks that SDA stays released while SCL is held, and that a refusal written at release silences the rest of the transfer. A START inside a byte checks that stale bits from that byte are not kept.

// File: rtl/i2cam_pkg.sv
package i2cam_pkg;
    localparam int BYTE_W = 8;
    localparam int REG_AW = 3;
    localparam int HI_W   = 2;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [4:0] TEN_TAG = 5'b11110;

    localparam logic [REG_AW-1:0] RA_CFG   = REG_AW'(0);
    localparam logic [REG_AW-1:0] RA_OWN   = REG_AW'(1);
    localparam logic [REG_AW-1:0] RA_OWNHI = REG_AW'(2);
    localparam logic [REG_AW-1:0] RA_MASK  = REG_AW'(3);
    localparam logic [REG_AW-1:0] RA_BUF   = REG_AW'(4);
    localparam logic [REG_AW-1:0] RA_FLAGS = REG_AW'(5);

    localparam int CB_MODE10 = 0;
    localparam int CB_GC     = 1;
    localparam int CB_HOLD   = 2;
    localparam int CB_ACKV   = 3;
    localparam int CB_REL    = 4;

    localparam int FB_IRQ  = 0;
    localparam int FB_BF   = 1;
    localparam int FB_UA   = 2;
    localparam int FB_HOLD = 3;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR1, ST_ADDR2, ST_DATA, ST_ACK, ST_HOLD, ST_SKIP
    } phase_e;

    typedef struct packed {
        logic              mode10;
        logic              gc_en;
        logic              hold_en;
        logic [BYTE_W-1:0] own;
        logic [HI_W-1:0]   own_hi;
        logic [BYTE_W-1:0] mask;
    } cfg_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic scl;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic   ack;
        logic   final_addr;
        logic   set_ua;
        phase_e nxt;
    } verdict_t;

    // Decide what a completed byte means in the current phase.
    function automatic verdict_t judge(phase_e ph, logic [BYTE_W-1:0] b, cfg_t c);
        verdict_t v;
        logic     is_gc;
        v.ack        = 1'b0;
        v.final_addr = 1'b0;
        v.set_ua     = 1'b0;
        v.nxt        = ST_SKIP;
        is_gc        = c.gc_en && (b == '0);
        case (ph)
            ST_ADDR1: begin
                if (is_gc) begin
                    v.ack = 1'b1; v.final_addr = 1'b1; v.nxt = ST_DATA;
                end else if (!c.mode10) begin
                    if (((b ^ c.own) & c.mask & {{(BYTE_W-1){1'b1}}, 1'b0}) == '0) begin
                        v.ack = 1'b1; v.final_addr = 1'b1;
                        v.nxt = b[0] ? ST_SKIP : ST_DATA;
                    end
                end else if (b[BYTE_W-1 -: 5] == TEN_TAG && b[HI_W:1] == c.own_hi) begin
                    v.ack = 1'b1; v.set_ua = 1'b1;
                    v.nxt = b[0] ? ST_SKIP : ST_ADDR2;
                end
            end
            ST_ADDR2: begin
                if (((b ^ c.own) & c.mask) == '0) begin
                    v.ack = 1'b1; v.final_addr = 1'b1; v.set_ua = 1'b1; v.nxt = ST_DATA;
                end
            end
            ST_DATA: begin
                v.ack = 1'b1; v.nxt = ST_DATA;
            end
            default: ;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/i2cam_sync.sv
module i2cam_sync
    import i2cam_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_raw,
    input  logic    sda_raw,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic              scl_d, sda_d, scl_n, sda_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_raw};
            sda_sh <= {sda_sh[STAGES-2:0], sda_raw};
            scl_d  <= scl_n;
            sda_d  <= sda_n;
        end
    end

    always_comb begin
        scl_n    = scl_sh[STAGES-1];
        sda_n    = sda_sh[STAGES-1];
        ev.scl   = scl_n;
        ev.sda   = sda_n;
        ev.rise  = scl_n && !scl_d;
        ev.fall  = !scl_n && scl_d;
        ev.start = scl_n && scl_d && sda_d && !sda_n;
        ev.stop  = scl_n && scl_d && !sda_d && sda_n;
    end
endmodule

// File: rtl/i2cam_regs.sv
module i2cam_regs
    import i2cam_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              re,
    input  logic [REG_AW-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_data,
    input  logic              irq_set,
    input  logic              ua_set,
    input  logic              holding,
    output cfg_t              cfg,
    output logic [BYTE_W-1:0] rdata,
    output logic              irq,
    output logic              rel,
    output logic              rel_ack
);
    logic              mode10_q, gc_q, hold_q, ackv_q;
    logic [BYTE_W-1:0] own_q, mask_q, buf_q;
    logic [HI_W-1:0]   hi_q;
    logic              irq_q, bf_q, ua_q;
    logic              wr_cfg, wr_flags;

    assign wr_cfg   = we && (addr == RA_CFG);
    assign wr_flags = we && (addr == RA_FLAGS);
    assign rel      = wr_cfg && wdata[CB_REL];
    assign rel_ack  = wdata[CB_ACKV];
    assign irq      = irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode10_q <= 1'b0; gc_q <= 1'b0; hold_q <= 1'b0; ackv_q <= 1'b0;
            own_q <= '0; hi_q <= '0; mask_q <= '1; buf_q <= '0;
            irq_q <= 1'b0; bf_q <= 1'b0; ua_q <= 1'b0;
        end else begin
            if (wr_cfg) begin
                mode10_q <= wdata[CB_MODE10];
                gc_q     <= wdata[CB_GC];
                hold_q   <= wdata[CB_HOLD];
                ackv_q   <= wdata[CB_ACKV];
            end
            if (we && addr == RA_OWN)   own_q  <= wdata;
            if (we && addr == RA_OWNHI) hi_q   <= wdata[HI_W-1:0];
            if (we && addr == RA_MASK)  mask_q <= wdata;
            if (load) buf_q <= load_data;

            if (irq_set)                         irq_q <= 1'b1;
            else if (wr_flags && wdata[FB_IRQ])  irq_q <= 1'b0;
            if (ua_set)                          ua_q  <= 1'b1;
            else if (wr_flags && wdata[FB_UA])   ua_q  <= 1'b0;
            if (load)                            bf_q  <= 1'b1;
            else if (re && addr == RA_BUF)       bf_q  <= 1'b0;
        end
    end

    always_comb begin
        cfg.mode10  = mode10_q;
        cfg.gc_en   = gc_q;
        cfg.hold_en = hold_q;
        cfg.own     = own_q;
        cfg.own_hi  = hi_q;
        cfg.mask    = mask_q;
        rdata       = '0;
        case (addr)
            RA_CFG: begin
                rdata[CB_MODE10] = mode10_q;
                rdata[CB_GC]     = gc_q;
                rdata[CB_HOLD]   = hold_q;
                rdata[CB_ACKV]   = ackv_q;
            end
            RA_OWN:   rdata = own_q;
            RA_OWNHI: rdata = {{(BYTE_W-HI_W){1'b0}}, hi_q};
            RA_MASK:  rdata = mask_q;
            RA_BUF:   rdata = buf_q;
            RA_FLAGS: begin
                rdata[FB_IRQ]  = irq_q;
                rdata[FB_BF]   = bf_q;
                rdata[FB_UA]   = ua_q;
                rdata[FB_HOLD] = holding;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/i2cam_fsm.sv
module i2cam_fsm
    import i2cam_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  cfg_t              cfg,
    input  logic              rel,
    input  logic              rel_ack,
    output logic              sda_low,
    output logic              scl_hold,
    output logic              load,
    output logic [BYTE_W-1:0] load_data,
    output logic              irq_set,
    output logic              ua_set
);
    phase_e            st, nxt_q;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] sh;
    logic              held_q;
    logic              rx_phase, byte_done, hold_now;
    verdict_t          v;

    always_comb begin
        v         = judge(st, sh, cfg);
        rx_phase  = (st == ST_ADDR1) || (st == ST_ADDR2) || (st == ST_DATA);
        byte_done = rx_phase && ev.fall && (bitcnt == CNT_W'(BYTE_W));
        hold_now  = byte_done && v.ack && v.final_addr && cfg.hold_en;
        load      = 1'b0;
        irq_set   = 1'b0;
        ua_set    = 1'b0;
        load_data = sh;
        if (!ev.start && !ev.stop) begin
            if (hold_now) begin
                load = 1'b1; irq_set = 1'b1;
            end
            if (byte_done && v.ack && v.set_ua) ua_set = 1'b1;
            if (st == ST_ACK && ev.fall && sda_low && !held_q) begin
                load = 1'b1; irq_set = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE; nxt_q <= ST_SKIP; bitcnt <= '0; sh <= '0;
            sda_low <= 1'b0; scl_hold <= 1'b0; held_q <= 1'b0;
        end else if (ev.stop) begin
            st <= ST_IDLE; bitcnt <= '0;
            sda_low <= 1'b0; scl_hold <= 1'b0; held_q <= 1'b0;
        end else if (ev.start) begin
            st <= ST_ADDR1; bitcnt <= '0;
            sda_low <= 1'b0; scl_hold <= 1'b0; held_q <= 1'b0;
        end else begin
            case (st)
                ST_ADDR1, ST_ADDR2, ST_DATA: begin
                    if (ev.rise && bitcnt < CNT_W'(BYTE_W)) begin
                        sh     <= {sh[BYTE_W-2:0], ev.sda};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_done) begin
                        bitcnt <= '0;
                        nxt_q  <= v.ack ? v.nxt : ST_SKIP;
                        if (hold_now) begin
                            st <= ST_HOLD; scl_hold <= 1'b1; held_q <= 1'b1;
                        end else begin
                            st <= ST_ACK; sda_low <= v.ack; held_q <= 1'b0;
                        end
                    end
                end
                ST_HOLD: begin
                    if (rel) begin
                        scl_hold <= 1'b0;
                        sda_low  <= !rel_ack;
                        st       <= ST_ACK;
                        if (rel_ack) nxt_q <= ST_SKIP;
                    end
                end
                ST_ACK: begin
                    if (ev.fall) begin
                        sda_low <= 1'b0;
                        st      <= nxt_q;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2cam_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_hold,
    output logic              sda_low,
    output logic              irq,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata
);
    bus_ev_t           ev;
    cfg_t              cfg;
    logic              rel, rel_ack, load, irq_set, ua_set;
    logic [BYTE_W-1:0] load_data;

    i2cam_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_raw(scl_in), .sda_raw(sda_in), .ev(ev)
    );

    i2cam_fsm u_fsm (
        .clk(clk), .rst(rst), .ev(ev), .cfg(cfg), .rel(rel), .rel_ack(rel_ack),
        .sda_low(sda_low), .scl_hold(scl_hold), .load(load), .load_data(load_data),
        .irq_set(irq_set), .ua_set(ua_set)
    );

    i2cam_regs u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .re(reg_re), .addr(reg_addr),
        .wdata(reg_wdata), .load(load), .load_data(load_data), .irq_set(irq_set),
        .ua_set(ua_set), .holding(scl_hold), .cfg(cfg), .rdata(reg_rdata),
        .irq(irq), .rel(rel), .rel_ack(rel_ack)
    );
endmodule

// File: rtl/i2cam_checker.sv
module i2cam_checker
    import i2cam_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sda_low,
    input logic              scl_hold,
    input logic              irq,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic [BYTE_W-1:0] reg_wdata,
    input logic              ev_stop,
    input logic              ev_fall,
    input logic              ev_scl
);
    logic irq_clr;
    assign irq_clr = reg_we && (reg_addr == RA_FLAGS) && reg_wdata[FB_IRQ];

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!sda_low && !scl_hold && !irq));

    a_r2_ack_while_scl_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_low) |-> !ev_scl);

    a_r6_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq);

    a_r6_irq_on_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(ev_fall));

    a_r10_hold_sda_free: assert property (@(posedge clk) disable iff (rst)
        scl_hold |-> !sda_low);

    a_r11_stop_release: assert property (@(posedge clk) disable iff (rst)
        ev_stop |=> (!sda_low && !scl_hold));
endmodule

bind i2c_addr_match i2cam_checker u_chk (
    .clk(clk), .rst(rst), .sda_low(sda_low), .scl_hold(scl_hold), .irq(irq),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .ev_stop(ev.stop), .ev_fall(ev.fall), .ev_scl(ev.scl)
);

// File: tb/sim_i2c_addr_match.sv
module sim_i2c_addr_match;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_drv = 1'b1, sda_drv = 1'b1;
    logic       reg_we = 1'b0, reg_re = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       scl_hold, sda_low, irq;
    wire        scl_in = scl_drv & ~scl_hold;
    wire        sda_in = sda_drv & ~sda_low;
    int         n_chk = 0, n_fail = 0;
    bit         done = 0;

    always #10 clk = ~clk;

    i2c_addr_match u0 (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .scl_hold(scl_hold), .sda_low(sda_low), .irq(irq),
        .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_re = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk); reg_re = 1'b0;
    endtask

    task automatic bus_start;
        sda_drv = 1'b1; idle(4); scl_drv = 1'b1; idle(6);
        sda_drv = 1'b0; idle(6); scl_drv = 1'b0; idle(4);
    endtask

    task automatic bus_stop;
        sda_drv = 1'b0; idle(4); scl_drv = 1'b1; idle(6);
        sda_drv = 1'b1; idle(6);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_drv = b[i]; idle(4); scl_drv = 1'b1; idle(8); scl_drv = 1'b0; idle(4);
        end
        sda_drv = 1'b1;
        idle(2);
    endtask

    task automatic ack_clock(output logic a);
        while (scl_hold) idle(1);
        idle(2); scl_drv = 1'b1; idle(4);
        a = ~sda_in;
        idle(4); scl_drv = 1'b0; idle(6);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic a);
        send_bits(b, 8);
        ack_clock(a);
    endtask

    function automatic logic exp_ack7(input logic [7:0] b, own, mask, input logic gc);
        if (gc && b == 8'h00) return 1'b1;
        return ((b ^ own) & mask & 8'hFE) == 8'h00;
    endfunction

    task automatic clear_all;
        logic [7:0] d;
        wr(3'd5, 8'h05);
        rd(3'd4, d);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d, own, mask, b, db;
        logic       a, gc;
        void'($urandom(32'd12345));
        idle(4); rst = 1'b0; idle(4);

        // R1 reset state
        rd(3'd0, d); chk("R1 cfg", d, 8'h00);
        rd(3'd3, d); chk("R1 mask", d, 8'hFF);
        rd(3'd5, d); chk("R1 flags", d, 8'h00);
        chk("R1 pins", {sda_low, scl_hold, irq}, 3'b000);

        // R4 general call disabled: 0x00 compared as an address
        wr(3'd1, 8'h20); wr(3'd0, 8'h00);
        bus_start; send_byte(8'h00, a); chk("R4 gc off nack", a, 1'b0);
        chk("R6 no irq on nack", irq, 1'b0);
        send_byte(8'h20, a); chk("R2 ignored after nack", a, 1'b0);
        bus_stop;

        // Random 7-bit sweep, R2 R3 R4 R5 R6 R7 R12
        for (int it = 0; it < 24; it++) begin
            own  = 8'($urandom);
            mask = ($urandom % 3 == 0) ? 8'hFF : 8'($urandom);
            gc   = 1'($urandom);
            case ($urandom % 4)
                0: b = own ^ (8'($urandom) & ~mask);
                1: b = 8'($urandom);
                2: b = 8'h00;
                default: b = own ^ (8'h02 << ($urandom % 7));
            endcase
            wr(3'd0, {6'd0, gc, 1'b0}); wr(3'd1, own); wr(3'd3, mask);
            clear_all;
            bus_start; send_byte(b, a);
            chk((gc && b == 0) ? "R4 gc" : (mask != 8'hFF ? "R3 mask" : "R2 match"),
                a, exp_ack7(b, own, mask, gc));
            if (exp_ack7(b, own, mask, gc)) begin
                chk("R6 irq", irq, 1'b1);
                rd(3'd5, d); chk("R7 bf set", d[1], 1'b1);
                rd(3'd4, d); chk("R5 addr byte in buf", d, b);
                rd(3'd5, d); chk("R7 bf clear", d[1], 1'b0);
                db = 8'($urandom);
                send_byte(db, a);
                if (b[0] && !(gc && b == 0)) chk("R12 read skip", a, 1'b0);
                else begin
                    chk("R5 data ack", a, 1'b1);
                    rd(3'd4, d); chk("R5 data buf", d, db);
                end
            end else begin
                chk("R6 irq clear", irq, 1'b0);
                send_byte(own, a); chk("R2 skip rest", a, 1'b0);
            end
            bus_stop;
        end

        // R6 sticky
        wr(3'd5, 8'h00); chk("R6 sticky", irq, 1'b1);
        wr(3'd5, 8'h01); chk("R6 cleared", irq, 1'b0);

        // R8 10-bit addressing
        wr(3'd0, 8'h01); wr(3'd2, 8'h02); wr(3'd1, 8'h5A); wr(3'd3, 8'hFF);
        clear_all;
        bus_start; send_byte(8'hF4, a); chk("R8 high ack", a, 1'b1);
        rd(3'd5, d); chk("R8 ua", d[2], 1'b1);
        wr(3'd5, 8'h04);
        send_byte(8'h5A, a); chk("R8 low ack", a, 1'b1);
        rd(3'd5, d); chk("R8 ua low", d[2], 1'b1);
        send_byte(8'h3C, a); chk("R5 10bit data", a, 1'b1);
        rd(3'd4, d); chk("R5 10bit buf", d, 8'h3C);
        bus_stop;
        wr(3'd3, 8'h00);
        bus_start; send_byte(8'hF2, a); chk("R8 high not masked", a, 1'b0);
        bus_stop;
        wr(3'd3, 8'hF0);
        bus_start; send_byte(8'hF4, a);
        send_byte(8'h55, a); chk("R3 10bit low masked", a, 1'b1);
        bus_stop;
        wr(3'd3, 8'hFF);
        bus_start; send_byte(8'hF4, a);
        send_byte(8'h5B, a); chk("R8 low mismatch", a, 1'b0);
        bus_stop;

        // R9 10-bit general call
        wr(3'd0, 8'h03); wr(3'd5, 8'h05);
        bus_start; send_byte(8'h00, a); chk("R9 gc ack", a, 1'b1);
        rd(3'd5, d); chk("R9 no ua", d[2], 1'b0);
        send_byte(8'h81, a); chk("R9 data ack", a, 1'b1);
        rd(3'd4, d); chk("R9 data buf", d, 8'h81);
        bus_stop;

        // R10 hold with ACK
        wr(3'd0, 8'h04); wr(3'd1, 8'h42); clear_all;
        bus_start; send_bits(8'h42, 8); idle(4);
        chk("R10 scl held", scl_hold, 1'b1);
        chk("R10 sda free", sda_in, 1'b1);
        chk("R10 irq", irq, 1'b1);
        rd(3'd4, d); chk("R10 buf", d, 8'h42);
        rd(3'd5, d); chk("R10 hold flag", d[3], 1'b1);
        wr(3'd0, 8'h14); idle(2);
        chk("R10 released", scl_hold, 1'b0);
        ack_clock(a); chk("R10 ack", a, 1'b1);
        send_byte(8'h99, a); chk("R10 data after hold", a, 1'b1);
        bus_stop;
        // R10 hold with NACK
        bus_start; send_bits(8'h42, 8); idle(4);
        chk("R10 held again", scl_hold, 1'b1);
        wr(3'd0, 8'h1C); idle(2);
        ack_clock(a); chk("R10 nack", a, 1'b0);
        send_byte(8'h11, a); chk("R10 ignored after nack", a, 1'b0);
        bus_stop;

        // R11 repeated start mid-byte, then stop releases
        wr(3'd0, 8'h00); wr(3'd1, 8'h30);
        bus_start; send_bits(8'hFF, 4);
        bus_start; send_byte(8'h30, a); chk("R11 restart ack", a, 1'b1);
        send_bits(8'h77, 8); idle(2);
        chk("R11 ack pending", sda_low, 1'b1);
        scl_drv = 1'b1; idle(8); scl_drv = 1'b0; idle(6);
        bus_stop; idle(4);
        chk("R11 stop release", {sda_low, scl_hold}, 2'b00);
        bus_start; send_byte(8'h31, a); chk("R12 read ack", a, 1'b1);
        send_byte(8'h30, a); chk("R12 read skip", a, 1'b0);
        bus_stop;

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule